// File: doc/BRIEF.md
# Automatic Register Update Strobe Generator

This block produces the strobe that moves written configuration values into the rest of the chip. It has two sources, selected by a single mode bit. In internal mode, a small binary prescaler divides the sync clock, and its ticks step a 32-bit interval counter. Each time the counter runs out, the block emits a single-cycle strobe, drives that strobe onto the shared update pad, and reloads the counter. In external mode, the pad is an input. A two-flop synchronizer follows it, and each rising edge of the pad becomes one strobe pulse.

The sync clock is the only clock. It runs at a quarter of the system clock. The mode bit, prescale code and interval are plain static control inputs with no handshake, because no data stream passes through the block. When internal mode is switched on, the prescaler and the counter restart, so the first strobe comes at a known distance from the enabling edge.

Top module: `ioup_strobe_gen`

## Requirements
- R1: While rst_n is low and on the first cycle after it, upd_strobe, upd_pin_oe and upd_pin_out are all 0.
- R2: The prescale code sets the tick divisor D: 2'b00 gives D=1, 2'b01 gives D=2, 2'b10 gives D=4 and 2'b11 gives D=8.
- R3: In internal mode with interval N, the strobe is high in the cycle after the (N+1)*D-th rising edge that follows the edge which first sampled int_mode high. It repeats every (N+1)*D cycles after that.
- R4: When (N+1)*D > 1, each internal strobe lasts exactly one sync-clock cycle.
- R5: upd_pin_oe equals int_mode as sampled at the previous rising edge.
- R6: upd_pin_out equals upd_strobe while upd_pin_oe is 1, and is 0 while upd_pin_oe is 0.
- R7: In external mode, a rising edge on upd_pin_in gives exactly one strobe cycle, which is high after the third rising edge that follows the change. Holding the pad high or lowering it gives no strobe.
- R8: In internal mode, activity on upd_pin_in does not change when the strobe occurs.
- R9: In external mode, the prescale code and the interval have no effect: with the pad held low, no strobe occurs.
- R10: When int_mode is dropped and raised again, counting restarts. The first strobe follows the timing of R3 measured from the new enabling edge, and no strobe occurs in the cycle just after enabling.
- R11: On expiry, the counter reloads the interval value present at that time. A change to the interval during a count therefore applies from the next period onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sync | input | 1 | Sync clock (a quarter of the system clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| int_mode | input | 1 | 1 selects internal generation; 0 makes the pad an input |
| ps_code | input | 2 | Prescale select (R2 encoding) |
| interval | input | 32 | Reload value N of the interval counter |
| upd_pin_in | input | 1 | Level received from the update pad |
| upd_strobe | output | 1 | Single-cycle update strobe |
| upd_pin_oe | output | 1 | Pad output enable |
| upd_pin_out | output | 1 | Level driven onto the pad when enabled |

## Verification
Every output comes from a register. upd_pin_oe follows int_mode one edge later. The internal strobe appears (N+1)*D edges after the enabling edge. The external strobe appears three edges after the pad rises: two synchronizer stages and the strobe register. The bench changes inputs on falling edges and reads outputs on falling edges. It counts rising edges from the enabling or pad-change edge and compares each cycle of a window against the one cycle in which a pulse is due, so an early, late, doubled or stretched pulse shows up as a mismatch at a known index.

// File: rtl/ioup_pkg.sv
package ioup_pkg;
  localparam int PS_CODE_W = 2;
  localparam int IVAL_W    = 32;
  localparam int SYNC_STG  = 2;

  typedef enum logic [PS_CODE_W-1:0] {
    PS_DIV1 = 2'b00,
    PS_DIV2 = 2'b01,
    PS_DIV4 = 2'b10,
    PS_DIV8 = 2'b11
  } ps_code_e;
endpackage

// File: rtl/ioup_prescaler.sv
module ioup_prescaler #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   div_m1;

  always_comb begin
    div_m1 = ({{CNT_W{1'b0}}, 1'b1} << code) - {{CNT_W{1'b0}}, 1'b1};
    tick   = run && ({1'b0, cnt_q} >= div_m1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0) |=> (!tick || code == '0)); // R2
endmodule

// File: rtl/ioup_interval_counter.sv
module ioup_interval_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] reload_i,
  output logic         fire_o
);
  logic [W-1:0] cnt_q;

  assign fire_o = run && tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= reload_i;
    else if (fire_o)    cnt_q <= reload_i;
    else if (tick)      cnt_q <= cnt_q - 1'b1;
  end

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == $past(reload_i))); // R11
endmodule

// File: rtl/ioup_edge_sync.sv
module ioup_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ioup_strobe_gen.sv
module ioup_strobe_gen
  import ioup_pkg::*;
#(
  parameter int CODE_W = PS_CODE_W,
  parameter int IW     = IVAL_W,
  parameter int STG    = SYNC_STG
) (
  input  logic              clk_sync,
  input  logic              rst_n,
  input  logic              int_mode,
  input  logic [CODE_W-1:0] ps_code,
  input  logic [IW-1:0]     interval,
  input  logic              upd_pin_in,
  output logic              upd_strobe,
  output logic              upd_pin_oe,
  output logic              upd_pin_out
);
  logic mode_q;
  logic run;
  logic tick;
  logic fire;
  logic ext_rise;
  logic strobe_q;

  assign run = int_mode & mode_q;

  ioup_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk(clk_sync), .rst_n(rst_n), .run(run), .code(ps_code), .tick(tick)
  );

  ioup_interval_counter #(.W(IW)) u_cnt (
    .clk(clk_sync), .rst_n(rst_n), .run(run), .tick(tick),
    .reload_i(interval), .fire_o(fire)
  );

  ioup_edge_sync #(.STAGES(STG)) u_sync (
    .clk(clk_sync), .rst_n(rst_n), .pin(upd_pin_in), .rise(ext_rise)
  );

  always_ff @(posedge clk_sync) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      mode_q   <= int_mode;
      strobe_q <= int_mode ? fire : ext_rise;
    end
  end

  assign upd_strobe  = strobe_q;
  assign upd_pin_oe  = mode_q;
  assign upd_pin_out = strobe_q & mode_q;

  AST_OE_IDLE: assert property (@(posedge clk_sync) disable iff (!rst_n)
    !upd_pin_oe |-> !upd_pin_out); // R6
  AST_ENABLE_QUIET: assert property (@(posedge clk_sync) disable iff (!rst_n)
    $rose(upd_pin_oe) |-> !upd_strobe); // R10
  AST_EXT_SINGLE: assert property (@(posedge clk_sync) disable iff (!rst_n)
    (upd_strobe && !upd_pin_oe) |=> !upd_strobe); // R7
endmodule

// File: tb/tb_ioup_strobe_gen.sv
module tb_ioup_strobe_gen;
  localparam time CLK_P = 10ns;

  logic        clk_sync = 1'b0;
  logic        rst_n;
  logic        int_mode;
  logic [1:0]  ps_code;
  logic [31:0] interval;
  logic        upd_pin_in;
  logic        upd_strobe, upd_pin_oe, upd_pin_out;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk_sync = ~clk_sync;

  ioup_strobe_gen dut (
    .clk_sync(clk_sync), .rst_n(rst_n), .int_mode(int_mode), .ps_code(ps_code),
    .interval(interval), .upd_pin_in(upd_pin_in), .upd_strobe(upd_strobe),
    .upd_pin_oe(upd_pin_oe), .upd_pin_out(upd_pin_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic go_external();
    @(negedge clk_sync);
    int_mode   = 1'b0;
    upd_pin_in = 1'b0;
    repeat (4) @(negedge clk_sync);
  endtask

  // R2 R3 R4 R5 R6: strobe spacing for one prescale code and interval
  task automatic t_internal(input logic [1:0] code, input int n);
    int p = (n + 1) * (1 << code);
    int miss = 0;
    int miss_k = 0;
    int miss_v = 0;
    go_external();
    ps_code  = code;
    interval = n;
    int_mode = 1'b1;
    @(negedge clk_sync);
    check(upd_pin_oe == 1'b1, "R5", "oe after enable", upd_pin_oe, 1);
    check(upd_strobe == 1'b0, "R10", "strobe at enable", upd_strobe, 0);
    for (int k = 1; k <= 2 * p; k++) begin
      @(negedge clk_sync);
      if (upd_strobe != (k == p || k == 2 * p) || upd_pin_out != upd_strobe) begin
        if (miss == 0) begin miss_k = k; miss_v = upd_strobe; end
        miss++;
      end
    end
    check(miss == 0, "R3", $sformatf("code=%0d n=%0d first bad cycle %0d strobe", code, n, miss_k),
          miss_v, (miss_k == p || miss_k == 2 * p) ? 1 : 0);
    go_external();
  endtask

  // R7 R6 R5: pad rising edge gives one pulse after three edges
  task automatic t_external();
    int miss = 0;
    go_external();
    upd_pin_in = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk_sync);
      if (upd_strobe != (k == 3)) miss++;
      if (upd_pin_out != 1'b0 || upd_pin_oe != 1'b0) miss++;
    end
    check(miss == 0, "R7", "external rise pulse and hold", miss, 0);
    upd_pin_in = 1'b0;
    miss = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk_sync);
      if (upd_strobe) miss++;
    end
    check(miss == 0, "R7", "falling pad edge strobes", miss, 0);
    check(upd_pin_out == 1'b0, "R6", "pin_out in external mode", upd_pin_out, 0);
  endtask

  // R9: timer settings do nothing in external mode
  task automatic t_ignore_timer();
    int hits = 0;
    go_external();
    ps_code  = 2'b00;
    interval = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_sync);
      if (upd_strobe) hits++;
    end
    check(hits == 0, "R9", "strobes with timer set but external mode", hits, 0);
  endtask

  // R8: pad toggling does not disturb internal timing
  task automatic t_pad_ignored();
    int miss = 0;
    go_external();
    ps_code  = 2'b00;
    interval = 9;
    int_mode = 1'b1;
    @(negedge clk_sync);
    for (int k = 1; k <= 20; k++) begin
      upd_pin_in = ~upd_pin_in;
      @(negedge clk_sync);
      if (upd_strobe != (k == 10 || k == 20)) miss++;
    end
    check(miss == 0, "R8", "strobe timing with pad toggling", miss, 0);
    upd_pin_in = 1'b0;
    go_external();
  endtask

  // R10: drop and raise the mode bit mid-count
  task automatic t_restart();
    int miss = 0;
    go_external();
    ps_code  = 2'b00;
    interval = 5;
    int_mode = 1'b1;
    repeat (4) @(negedge clk_sync);
    int_mode = 1'b0;
    @(negedge clk_sync);
    check(upd_pin_oe == 1'b0, "R5", "oe after disable", upd_pin_oe, 0);
    int_mode = 1'b1;
    @(negedge clk_sync);
    check(upd_strobe == 1'b0, "R10", "strobe right after re-enable", upd_strobe, 0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk_sync);
      if (upd_strobe != (k == 6)) miss++;
    end
    check(miss == 0, "R10", "first strobe after restart", miss, 0);
    go_external();
  endtask

  // R11 R4: interval change takes effect at next reload
  task automatic t_reload();
    int miss = 0;
    int width = 0;
    go_external();
    ps_code  = 2'b00;
    interval = 2;
    int_mode = 1'b1;
    @(negedge clk_sync);
    interval = 4;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk_sync);
      if (upd_strobe != (k == 3 || k == 8 || k == 13)) miss++;
      if (upd_strobe) width++;
    end
    check(miss == 0, "R11", "periods after interval change", miss, 0);
    check(width == 3, "R4", "strobe cycles in window", width, 3);
    go_external();
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; int_mode = 1'b0; ps_code = 2'b00; interval = 0; upd_pin_in = 1'b0;
    repeat (3) @(negedge clk_sync);
    check(upd_strobe == 1'b0 && upd_pin_oe == 1'b0 && upd_pin_out == 1'b0, "R1",
          "outputs in reset", {upd_strobe, upd_pin_oe, upd_pin_out}, 0);
    rst_n = 1'b1;
    @(negedge clk_sync);
    check(upd_strobe == 1'b0 && upd_pin_oe == 1'b0, "R1", "outputs after reset",
          {upd_strobe, upd_pin_oe}, 0);
    t_internal(2'b00, 3);
    t_internal(2'b01, 2);
    t_internal(2'b10, 1);
    t_internal(2'b11, 0);
    t_internal(2'b11, 2);
    t_external();
    t_ignore_timer();
    t_pad_ignored();
    t_restart();
    t_reload();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule